// File: doc/BRIEF.md
# Windowed Deadman Timer with Two-Key Restart

This block is a deadman timer for a processor subsystem. When it is enabled it counts system clock cycles. If software does not restart it before the count reaches a programmed period, it flags a timeout, asks the system for a reset, and leaves a sticky cause bit for boot code to inspect. A timer that any stray store could restart would be weak protection, so a restart takes two keyed writes in order.

The first write arms the timer. The second write fires the restart. The firing write is accepted only while a service window is open: the window opens when the count is within a programmed interval of the period. A firing write that comes too early, comes without an arming write, or carries the wrong key does not restart the count. Neither does an arming write with the wrong key. Each of these latches an error flag in the status word and raises the reset request.

The register file sits on a plain single-cycle read/write port with 32-bit data. Reads are combinational in the cycle of the strobe. For one cycle after software switches the timer off, the port ignores all traffic.

Top module: `wdw_deadman`

## Requirements
- R1: After reset the timer is off. Control, count and status read 0. Period reads 100000 and window reads 25000. `reset_req` is 0 and `rst_cause` is 0.
- R2: Control bit 15 is the run bit. While it is 1 the count rises by exactly one per clock, starting at 0. A control write with bit 15 = 0 while running stops the timer, returns the count to 0, and clears the status flags and the arming state.
- R3: When the count reaches the period value, status bit 5 (timeout) sets, status bit 0 clears and `reset_req` rises. The count then holds at the period value until the timer is stopped.
- R4: Status bit 0 (window open) reads 1 once the count is at least period minus window, and at least 1. It reads 0 before that point and once the timeout occurs. When window is not less than period, the threshold is 0.
- R5: A write to offset 0x10 whose bits 15:8 equal 0x40 arms the restart. Any other value in those bits sets status bit 7 and raises `reset_req`.
- R6: A write to offset 0x20 whose bits 7:0 equal 0x08, made while the timer is armed and the window is open, returns the count to 0. It also clears the window bit and the arming. No error flag is set.
- R7: Any other write to offset 0x20 sets status bit 6 and raises `reset_req`, leaves the count running, and uses up the arming. This covers a wrong key, no prior arming, or a closed window.
- R8: A timeout sets bit 5 of `rst_cause`. That bit stays set after the timer is stopped, until a one-cycle pulse on `cause_clr` clears it.
- R9: In the cycle right after a write that stops the timer, the port ignores writes (period, window and run bit keep their values) and reads return 0.
- R10: The registers are at these offsets: control 0x00, arm 0x10, fire 0x20, status 0x30, count 0x40, period 0x60, window 0x70. Period and window read back as written. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the count advances on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_rd | input | 1 | Read strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| cause_clr | input | 1 | Pulse that clears the sticky timeout cause bit |
| reset_req | output | 1 | Reset request: timeout or any key error |
| rst_cause | output | 8 | Reset-cause flags; bit 5 records a timeout |

## Verification
The hardest case to reach is a firing write that lands on the exact cycle the window opens, or on the last cycle before the timeout. Whether it succeeds depends on the window flag as registered one edge earlier. The stimulus places arming and firing writes at random delays across many random period and window settings. It predicts the window state for the cycle each write is driven, so writes fall on both sides of both edges. Directed cases add the out-of-order and wrong-key sequences, the timeout with its sticky cause, and the single dead cycle after a stop.

// File: rtl/wdw_pkg.sv
`timescale 1ns/1ps
package wdw_pkg;
   // status bit positions decoded by software
   localparam int ST_WIN  = 0;
   localparam int ST_EVT  = 5;
   localparam int ST_BAD2 = 6;
   localparam int ST_BAD1 = 7;

   // register byte offsets decoded by software
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_ARM  = 8'h10;
   localparam logic [7:0] OFS_FIRE = 8'h20;
   localparam logic [7:0] OFS_STAT = 8'h30;
   localparam logic [7:0] OFS_CNT  = 8'h40;
   localparam logic [7:0] OFS_PER  = 8'h60;
   localparam logic [7:0] OFS_WIN  = 8'h70;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_CTRL, SEL_ARM, SEL_FIRE, SEL_STAT, SEL_CNT, SEL_PER, SEL_WIN
   } reg_sel_e;

   typedef struct packed {
      logic bad_arm;
      logic bad_fire;
      logic evt;
      logic win;
   } flags_t;
endpackage

// File: rtl/wdw_regs.sv
`timescale 1ns/1ps
module wdw_regs
   import wdw_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int KEY_W  = 8,
   parameter int EN_BIT = 15,
   parameter logic [CNT_W-1:0] PERIOD_RST = CNT_W'(100000),
   parameter logic [CNT_W-1:0] WINDOW_RST = CNT_W'(25000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  flags_t            flags,
   output logic [DATA_W-1:0] rdata,
   output logic              run,
   output logic [CNT_W-1:0]  period,
   output logic [CNT_W-1:0]  window,
   output logic              arm_wr,
   output logic              fire_wr,
   output logic              stop,
   output logic [KEY_W-1:0]  arm_key,
   output logic [KEY_W-1:0]  fire_key
);
   localparam int ARM_LO = KEY_W;
   localparam int ARM_HI = 2 * KEY_W - 1;

   initial begin
      if (ADDR_W < 7)          $error("wdw_regs: ADDR_W too small for the offset map");
      if (DATA_W < 2 * KEY_W)  $error("wdw_regs: DATA_W cannot hold both key fields");
      if (EN_BIT >= DATA_W)    $error("wdw_regs: EN_BIT outside the data word");
      if (CNT_W > DATA_W)      $error("wdw_regs: CNT_W wider than the data word");
   end

   logic             run_q, lock_q;
   logic [CNT_W-1:0] per_q, win_q;
   logic             wr_ok, rd_ok;
   reg_sel_e         sel;

   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      if (a == ADDR_W'(OFS_CTRL)) return SEL_CTRL;
      if (a == ADDR_W'(OFS_ARM))  return SEL_ARM;
      if (a == ADDR_W'(OFS_FIRE)) return SEL_FIRE;
      if (a == ADDR_W'(OFS_STAT)) return SEL_STAT;
      if (a == ADDR_W'(OFS_CNT))  return SEL_CNT;
      if (a == ADDR_W'(OFS_PER))  return SEL_PER;
      if (a == ADDR_W'(OFS_WIN))  return SEL_WIN;
      return SEL_NONE;
   endfunction

   assign sel     = decode(addr);
   assign wr_ok   = wr_en & ~lock_q;
   assign rd_ok   = rd_en & ~lock_q;
   assign stop    = wr_ok & (sel == SEL_CTRL) & ~wdata[EN_BIT] & run_q;
   assign arm_wr  = wr_ok & (sel == SEL_ARM);
   assign fire_wr = wr_ok & (sel == SEL_FIRE);
   assign arm_key  = wdata[ARM_HI:ARM_LO];
   assign fire_key = wdata[KEY_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         lock_q <= 1'b0;
         per_q  <= PERIOD_RST;
         win_q  <= WINDOW_RST;
      end else begin
         lock_q <= stop;
         if (wr_ok && sel == SEL_CTRL) run_q <= wdata[EN_BIT];
         if (wr_ok && sel == SEL_PER)  per_q <= wdata[CNT_W-1:0];
         if (wr_ok && sel == SEL_WIN)  win_q <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_ok) begin
         unique case (sel)
            SEL_CTRL: rdata[EN_BIT] = run_q;
            SEL_STAT: begin
               rdata[ST_WIN]  = flags.win;
               rdata[ST_EVT]  = flags.evt;
               rdata[ST_BAD2] = flags.bad_fire;
               rdata[ST_BAD1] = flags.bad_arm;
            end
            SEL_CNT:  rdata = DATA_W'(cnt);
            SEL_PER:  rdata = DATA_W'(per_q);
            SEL_WIN:  rdata = DATA_W'(win_q);
            default:  rdata = '0;
         endcase
      end
   end

   assign run    = run_q;
   assign period = per_q;
   assign window = win_q;

   // dead cycle after a stop leaves every writable field untouched
   assert_lockout_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> (run_q == $past(run_q) && per_q == $past(per_q) && win_q == $past(win_q)));

   // a stop always leaves the timer off
   assert_stop_clears_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !run_q);
endmodule

// File: rtl/wdw_count.sv
`timescale 1ns/1ps
module wdw_count #(
   parameter int CNT_W           = 32,
   parameter bit STOP_ON_TIMEOUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             stop,
   input  logic             restart,
   input  logic             cause_clr,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] window,
   output logic [CNT_W-1:0] cnt,
   output logic             win_open,
   output logic             evt,
   output logic             cause
);
   initial begin
      if (CNT_W < 2) $error("wdw_count: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q, thresh, nxt, after_cnt;
   logic             win_q, evt_q, cause_q;
   logic             reach, timeout;

   assign thresh  = (window >= period) ? '0 : (period - window);
   assign nxt     = cnt_q + CNT_W'(1);
   assign reach   = (nxt >= period);
   assign timeout = run & ~evt_q & ~stop & ~restart & reach;

   generate
      if (STOP_ON_TIMEOUT) begin : g_freeze
         assign after_cnt = cnt_q;
      end else begin : g_free
         assign after_cnt = nxt;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         win_q   <= 1'b0;
         evt_q   <= 1'b0;
         cause_q <= 1'b0;
      end else begin
         if (stop || restart) begin
            cnt_q <= '0;
            win_q <= 1'b0;
            if (stop) evt_q <= 1'b0;
         end else if (run) begin
            if (evt_q) begin
               cnt_q <= after_cnt;
            end else begin
               cnt_q <= nxt;
               if (reach) begin
                  evt_q <= 1'b1;
                  win_q <= 1'b0;
               end else begin
                  win_q <= (nxt >= thresh);
               end
            end
         end
         if (timeout)        cause_q <= 1'b1;
         else if (cause_clr) cause_q <= 1'b0;
      end
   end

   assign cnt      = cnt_q;
   assign win_open = win_q;
   assign evt      = evt_q;
   assign cause    = cause_q;

   assert_timeout_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> (evt && !win_open && cause));

   assert_evt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !stop) |=> evt);

   assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !stop) |=> (cnt == '0 && !win_open));

   assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cause && !cause_clr) |=> cause);

   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !stop && !restart) |=> $stable(cnt));
endmodule

// File: rtl/wdw_keys.sv
`timescale 1ns/1ps
module wdw_keys #(
   parameter int KEY_W = 8,
   parameter logic [KEY_W-1:0] KEY_ARM  = KEY_W'(8'h40),
   parameter logic [KEY_W-1:0] KEY_FIRE = KEY_W'(8'h08)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic             arm_wr,
   input  logic [KEY_W-1:0] arm_key,
   input  logic             fire_wr,
   input  logic [KEY_W-1:0] fire_key,
   input  logic             win_open,
   output logic             restart,
   output logic             bad_arm,
   output logic             bad_fire
);
   initial begin
      if (KEY_ARM == KEY_FIRE) $error("wdw_keys: the two keys must differ");
   end

   logic arm_q, bad_arm_q, bad_fire_q;

   assign restart = fire_wr & (fire_key == KEY_FIRE) & arm_q & win_open;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q      <= 1'b0;
         bad_arm_q  <= 1'b0;
         bad_fire_q <= 1'b0;
      end else if (stop) begin
         arm_q      <= 1'b0;
         bad_arm_q  <= 1'b0;
         bad_fire_q <= 1'b0;
      end else begin
         if (arm_wr) begin
            if (arm_key == KEY_ARM) arm_q     <= 1'b1;
            else                    bad_arm_q <= 1'b1;
         end
         if (fire_wr) begin
            arm_q <= 1'b0;
            if (!restart) bad_fire_q <= 1'b1;
         end
      end
   end

   assign bad_arm  = bad_arm_q;
   assign bad_fire = bad_fire_q;

   assert_bad_arm_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_wr && arm_key != KEY_ARM) |=> bad_arm);

   assert_fire_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_wr && !arm_q) |=> (bad_fire && !restart));

   assert_fire_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_wr && !win_open) |=> bad_fire);

   assert_good_fire_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !bad_fire) |=> !bad_fire);
endmodule

// File: rtl/wdw_deadman.sv
`timescale 1ns/1ps
module wdw_deadman
   import wdw_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter int KEY_W     = 8,
   parameter int EN_BIT    = 15,
   parameter logic [KEY_W-1:0] KEY_ARM  = KEY_W'(8'h40),
   parameter logic [KEY_W-1:0] KEY_FIRE = KEY_W'(8'h08),
   parameter logic [CNT_W-1:0] PERIOD_RST = CNT_W'(100000),
   parameter logic [CNT_W-1:0] WINDOW_RST = CNT_W'(25000),
   parameter int CAUSE_W   = 8,
   parameter int CAUSE_BIT = 5,
   parameter bit STOP_ON_TIMEOUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cause_clr,
   output logic              reset_req,
   output logic [CAUSE_W-1:0] rst_cause
);
   initial begin
      if (CAUSE_BIT >= CAUSE_W) $error("wdw_deadman: CAUSE_BIT outside rst_cause");
   end

   logic             run, stop, restart;
   logic             arm_wr, fire_wr;
   logic [KEY_W-1:0] arm_key, fire_key;
   logic [CNT_W-1:0] period, window, cnt;
   logic             win_open, evt, cause, bad_arm, bad_fire;
   flags_t           flags;

   assign flags = '{bad_arm: bad_arm, bad_fire: bad_fire, evt: evt, win: win_open};

   wdw_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W),
      .EN_BIT(EN_BIT), .PERIOD_RST(PERIOD_RST), .WINDOW_RST(WINDOW_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
      .addr(bus_addr), .wdata(bus_wdata), .cnt(cnt), .flags(flags),
      .rdata(bus_rdata), .run(run), .period(period), .window(window),
      .arm_wr(arm_wr), .fire_wr(fire_wr), .stop(stop),
      .arm_key(arm_key), .fire_key(fire_key)
   );

   wdw_count #(
      .CNT_W(CNT_W), .STOP_ON_TIMEOUT(STOP_ON_TIMEOUT)
   ) u_count (
      .clk(clk), .rst_n(rst_n), .run(run), .stop(stop), .restart(restart),
      .cause_clr(cause_clr), .period(period), .window(window),
      .cnt(cnt), .win_open(win_open), .evt(evt), .cause(cause)
   );

   wdw_keys #(
      .KEY_W(KEY_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)
   ) u_keys (
      .clk(clk), .rst_n(rst_n), .stop(stop),
      .arm_wr(arm_wr), .arm_key(arm_key),
      .fire_wr(fire_wr), .fire_key(fire_key),
      .win_open(win_open), .restart(restart),
      .bad_arm(bad_arm), .bad_fire(bad_fire)
   );

   assign reset_req = evt | bad_arm | bad_fire;

   generate
      for (genvar i = 0; i < CAUSE_W; i++) begin : g_cause
         if (i == CAUSE_BIT) begin : g_live
            assign rst_cause[i] = cause;
         end else begin : g_zero
            assign rst_cause[i] = 1'b0;
         end
      end
   endgenerate

   // a key error seen at the port keeps the reset request up until a stop
   assert_req_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_req && !stop) |=> reset_req);
endmodule

// File: tb/wdw_deadman_tb.sv
`timescale 1ns/1ps
module wdw_deadman_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cause_clr = 1'b0;
   logic        reset_req;
   logic [7:0]  rst_cause;

   int          checks = 0;
   int          fails = 0;
   int unsigned cyc = 0;
   bit          done = 1'b0;

   // reference model state
   bit          m_en, m_arm, m_bad1, m_bad2, m_cause;
   int unsigned m_base, m_per, m_win;

   wdw_deadman u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cause_clr(cause_clr), .reset_req(reset_req), .rst_cause(rst_cause)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int unsigned thr_of(int unsigned p, int unsigned w);
      return (w >= p) ? 0 : p - w;
   endfunction

   function automatic logic [31:0] exp_cnt(int unsigned c);
      int unsigned k;
      if (!m_en) return 32'd0;
      k = c - m_base;
      return (k >= m_per) ? m_per : k;
   endfunction

   function automatic bit exp_evt(int unsigned c);
      return m_en && ((c - m_base) >= m_per);
   endfunction

   function automatic bit exp_win(int unsigned c);
      int unsigned k, t;
      if (!m_en) return 1'b0;
      k = c - m_base;
      t = thr_of(m_per, m_win);
      if (t < 1) t = 1;
      return (k >= t) && (k < m_per);
   endfunction

   function automatic logic [31:0] exp_stat(int unsigned c);
      logic [31:0] s;
      s = '0;
      s[0] = exp_win(c);
      s[5] = exp_evt(c);
      s[6] = m_bad2;
      s[7] = m_bad1;
      return s;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all bus tasks start at a falling edge and end at the next one
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v, output int unsigned c,
                     output logic req, output logic [7:0] cz);
      bus_rd = 1'b1; bus_addr = a;
      #1;
      v = bus_rdata; c = cyc; req = reset_req; cz = rst_cause;
      bus_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_enable(input int unsigned p, input int unsigned w);
      wr(8'h60, p);
      wr(8'h70, w);
      m_per = p; m_win = w;
      wr(8'h00, 32'h0000_8000);
      m_en = 1'b1; m_base = cyc;
   endtask

   task automatic do_disable();
      if (m_en && (cyc - m_base) >= m_per) m_cause = 1'b1;
      wr(8'h00, 32'h0);
      m_en = 1'b0; m_arm = 1'b0; m_bad1 = 1'b0; m_bad2 = 1'b0;
   endtask

   task automatic do_arm(input logic [7:0] key);
      wr(8'h10, {16'h0, key, 8'h00});
      if (key == 8'h40) m_arm = 1'b1;
      else              m_bad1 = 1'b1;
   endtask

   task automatic do_fire(input logic [7:0] key);
      bit ok;
      ok = (key == 8'h08) && m_arm && exp_win(cyc);
      wr(8'h20, {24'h0, key});
      m_arm = 1'b0;
      if (ok) m_base = cyc;
      else    m_bad2 = 1'b1;
   endtask

   task automatic pulse_cause_clr();
      cause_clr = 1'b1;
      @(negedge clk);
      cause_clr = 1'b0;
      m_cause = 1'b0;
   endtask

   // compare count, status, reset request and cause against the model
   task automatic compare_all(input string tag);
      logic [31:0] v; int unsigned c; logic req; logic [7:0] cz;
      rd(8'h40, v, c, req, cz);
      chk({tag, " count"}, v, exp_cnt(c));
      chk({tag, " reset_req"}, {31'h0, req},
          {31'h0, exp_evt(c) | m_bad1 | m_bad2});
      chk({tag, " cause"}, {24'h0, cz}, {24'h0, 2'b00, m_cause | exp_evt(c), 5'b0});
      rd(8'h30, v, c, req, cz);
      chk({tag, " status"}, v, exp_stat(c));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v; int unsigned c; logic req; logic [7:0] cz;
      void'($urandom(32'd20240611));
      m_en = 0; m_arm = 0; m_bad1 = 0; m_bad2 = 0; m_cause = 0;
      m_per = 100000; m_win = 25000; m_base = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, v, c, req, cz); chk("R1 control", v, 32'h0);
      chk("R1 reset_req", {31'h0, req}, 32'h0);
      chk("R1 rst_cause", {24'h0, cz}, 32'h0);
      rd(8'h40, v, c, req, cz); chk("R1 count", v, 32'h0);
      rd(8'h30, v, c, req, cz); chk("R1 status", v, 32'h0);
      rd(8'h60, v, c, req, cz); chk("R1 period", v, 32'd100000);
      rd(8'h70, v, c, req, cz); chk("R1 window", v, 32'd25000);

      // R10 unmapped offset reads zero, write has no effect
      wr(8'h50, 32'hFFFF_FFFF);
      rd(8'h50, v, c, req, cz); chk("R10 unmapped read", v, 32'h0);
      rd(8'h60, v, c, req, cz); chk("R10 period after stray write", v, 32'd100000);
      rd(8'h00, v, c, req, cz); chk("R10 control after stray write", v, 32'h0);

      // R2 counting, R4 window edges, R6 good restart
      do_enable(50, 10);
      rd(8'h00, v, c, req, cz); chk("R2 run bit", v, 32'h0000_8000);
      rd(8'h70, v, c, req, cz); chk("R10 window readback", v, 32'd10);
      compare_all("R2 early");
      compare_all("R2 next");
      do_arm(8'h40);
      idle(30);
      compare_all("R4 around threshold a");
      compare_all("R4 around threshold b");
      compare_all("R4 around threshold c");
      do_fire(8'h08);
      chk("R6 restart accepted", {31'h0, m_bad2}, 32'h0);
      compare_all("R6 after restart");

      // R7 fire while window closed
      do_arm(8'h40);
      do_fire(8'h08);
      compare_all("R7 fire before window");
      do_disable(); idle(1);
      compare_all("R2 after stop");

      // R5 wrong arming key
      do_enable(60, 20);
      do_arm(8'h41);
      compare_all("R5 bad arm key");
      do_disable(); idle(1);

      // R7 fire without arming, inside window
      do_enable(30, 20);
      idle(15);
      do_fire(8'h08);
      compare_all("R7 fire unarmed");
      do_disable(); idle(1);

      // R7 wrong fire key while armed and open
      do_enable(30, 20);
      do_arm(8'h40);
      idle(14);
      do_fire(8'h09);
      compare_all("R7 wrong fire key");
      do_disable(); idle(1);

      // R3 timeout and R8 sticky cause
      do_enable(20, 5);
      idle(30);
      compare_all("R3 timeout");
      do_disable(); idle(1);
      compare_all("R8 cause after stop");
      pulse_cause_clr();
      compare_all("R8 cause cleared");

      // R4 window at least period: opens right after start
      do_enable(16, 40);
      compare_all("R4 wide window a");
      compare_all("R4 wide window b");
      do_disable(); idle(1);

      // R9 lockout: read, period write and run write all ignored
      do_enable(40, 10);
      do_disable();
      rd(8'h60, v, c, req, cz); chk("R9 read during lockout", v, 32'h0);
      rd(8'h60, v, c, req, cz); chk("R9 read after lockout", v, 32'd40);
      do_enable(40, 10);
      do_disable();
      wr(8'h60, 32'd77);
      rd(8'h60, v, c, req, cz); chk("R9 period write ignored", v, 32'd40);
      do_enable(40, 10);
      do_disable();
      wr(8'h00, 32'h0000_8000);
      rd(8'h00, v, c, req, cz); chk("R9 run write ignored", v, 32'h0);
      compare_all("R9 timer still off");

      // random sequences across R2..R8
      for (int i = 0; i < 60; i++) begin
         int unsigned p, w;
         p = 12 + ($urandom % 40);
         w = $urandom % (p + 4);
         do_enable(p, w);
         idle($urandom % p);
         if (($urandom % 5) != 0) do_arm((($urandom % 5) != 0) ? 8'h40 : 8'h40 ^ (8'h01 << ($urandom % 8)));
         idle($urandom % 8);
         if (($urandom % 4) != 0) do_fire((($urandom % 6) != 0) ? 8'h08 : 8'h08 ^ (8'h01 << ($urandom % 8)));
         idle($urandom % p);
         compare_all("R2-random");
         compare_all("R4-random");
         do_disable(); idle(1);
         if (m_cause && ($urandom % 2)) begin
            pulse_cause_clr();
            compare_all("R8-random clear");
         end
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule